// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

The block contains a free-running 16-bit timer, which advances once per cycle while a timer clock enable is high. It also holds a 16-bit compare register and an operating-mode field. The timer is compared with the compare register in every cycle. When the two values match, the block carries out the action selected by the 4-bit mode. It can drive an output latch high, drive it low, or invert it. It can also raise only the compare interrupt flag, or fire an event trigger. The event trigger restarts the timer and can request the start of an analogue-to-digital conversion.

The event trigger pulses as soon as the match is seen. The timer restart is held back until the next timer enable. If software rewrites either compare byte in that gap, the pending restart is dropped. With the trigger mode left running, the compare value therefore sets the period of the timer, and a period lasts compare+1 enables. Software reaches the block through a byte-wide write port. The output pin is reported with a separate drive qualifier.

Top module: `cmp_event_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the timer reads 0 and every flag, pulse, latch and drive output is 0.
- R2: Each cycle with `tick_en` high advances the timer by one, and cycles without it leave the timer unchanged. The step from 0xFFFF to 0 sets `ovf_flag_o`, which stays set until `ovf_clr`. A set and a clear in the same cycle leave the flag set.
- R3: A write with `wr_sel`=0 loads compare bits 7:0, a write with `wr_sel`=1 loads bits 15:8, and a write with `wr_sel`=2 loads the mode from `wr_data[3:0]`. A match is the timer equal to the compare register in all 16 bits. In the modes 1000, 1001, 0010, 1010 and 1011 a match sets `cmp_flag_o` one cycle later, and the flag holds until `flag_clr`. A set wins over a clear in the same cycle.
- R4: On a match the latch on `pin_o` goes high in mode 1000, goes low in mode 1001 and inverts in mode 0010. It updates one cycle after the match cycle.
- R5: A matching timer value causes only one action, however many cycles the timer stays at that value.
- R6: Mode 1010 sets the flag and leaves both the latch and `pin_drive_o` untouched.
- R7: In mode 1011, a match makes `trig_o` pulse high for one cycle, one cycle after the match. `adc_start_o` pulses in that same cycle only if `adc_en` is high.
- R8: After a match in mode 1011, the next cycle with `tick_en` high loads 0 into the timer in place of the increment. This includes an enable in the match cycle itself. The timer therefore counts 0 up to the compare value, a period of compare+1 enables.
- R9: A restart caused by the trigger, including one from 0xFFFF, does not set `ovf_flag_o`.
- R10: A write to either compare byte between the trigger match and the restart cancels the restart, and the timer increments instead.
- R11: Writing mode 0000 drives the latch low at the write edge.
- R12: Every mode code outside 1000, 1001, 0010, 1010 and 1011 takes no action on a match. The flag and the latch stay as they were.
- R13: `pin_drive_o` is high one cycle after `oe_in` is high and the mode is 1000, 1001 or 0010. In any other case it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 compare low byte, 1 compare high byte, 2 mode |
| wr_data | input | 8 | Write data |
| oe_in | input | 1 | External pin output enable |
| flag_clr | input | 1 | Clears the compare flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| adc_en | input | 1 | Converter enabled; gates the start pulse |
| timer_o | output | 16 | Current timer value |
| pin_o | output | 1 | Compare output latch |
| pin_drive_o | output | 1 | Pin is driven by the latch |
| cmp_flag_o | output | 1 | Compare interrupt flag |
| ovf_flag_o | output | 1 | Timer overflow flag |
| trig_o | output | 1 | Event trigger pulse |
| adc_start_o | output | 1 | Conversion start pulse |

## Verification
A stuck once-per-value guard would show up on `pin_o` in toggle mode. A slow enable holds the timer at the matching value, and the latch would flip again on the very next idle cycle. A lost or stale restart request would show up on `timer_o` at the first enable after a trigger: the bench expects 0 after a clean trigger, and the incremented value after a cancelling write. A wrong overflow decision would show on `ovf_flag_o` in the cycle after a trigger restart from 0xFFFF.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF = 4'b0000,
    MD_TOG = 4'b0010,
    MD_SET = 4'b1000,
    MD_CLR = 4'b1001,
    MD_IRQ = 4'b1010,
    MD_SEV = 4'b1011
  } mode_e;

  function automatic logic mode_drives(input logic [MODE_W-1:0] m);
    return (m == MD_SET) || (m == MD_CLR) || (m == MD_TOG);
  endfunction

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return mode_drives(m) || (m == MD_IRQ) || (m == MD_SEV);
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 8,
  localparam int NB = TW / DW,
  localparam int SELW = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [TW-1:0]     cmp_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              cmp_wr_o,
  output logic              mode_zero_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [NB-1:0] byte_we;
  logic          mode_we;

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign byte_we[b] = wr_en && (wr_sel == SELW'(b));
  end

  assign mode_we     = wr_en && (wr_sel == SELW'(NB));
  assign cmp_wr_o    = |byte_we;
  assign mode_zero_o = mode_we && (wr_data[MODE_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_o  <= '0;
      mode_o <= MD_OFF;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) cmp_o[b*DW +: DW] <= wr_data;
      end
      if (mode_we) mode_o <= wr_data[MODE_W-1:0];
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          sev_hit_i,
  input  logic          cmp_wr_i,
  input  logic          ovf_clr_i,
  output logic [TW-1:0] cnt_o,
  output logic          ovf_o
);
  timeunit 1ns; timeprecision 1ps;

  logic pend_q;
  logic rst_req;
  logic wrap;

  assign rst_req = (pend_q || sev_hit_i) && !cmp_wr_i;
  assign wrap    = tick_i && !rst_req && (&cnt_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      pend_q <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      if (tick_i) cnt_o <= rst_req ? '0 : cnt_o + TW'(1);
      if (cmp_wr_i || tick_i) pend_q <= 1'b0;
      else if (sev_hit_i)     pend_q <= 1'b1;
      if (wrap)           ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i && !pend_q && !sev_hit_i |=> cnt_o == $past(cnt_o) + TW'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_o));
  // R10
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_wr_i |=> !pend_q);
  // R9
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> (&$past(cnt_o)) && cnt_o == '0 && !$past(sev_hit_i));
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] cmp_i,
  output logic          hit_o
);
  timeunit 1ns; timeprecision 1ps;

  logic done_q;

  assign hit_o = (cnt_i == cmp_i) && !done_q;

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= tick_i ? 1'b0 : (done_q || hit_o);
  end

  // R5
  once_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o && !tick_i |=> !hit_o);
endmodule

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              mode_zero_i,
  input  logic              oe_i,
  input  logic              flag_clr_i,
  input  logic              adc_en_i,
  output logic              sev_hit_o,
  output logic              latch_o,
  output logic              flag_o,
  output logic              trig_o,
  output logic              adc_o,
  output logic              drive_o
);
  timeunit 1ns; timeprecision 1ps;

  assign sev_hit_o = hit_i && (mode_i == MD_SEV);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_o <= 1'b0;
      flag_o  <= 1'b0;
      trig_o  <= 1'b0;
      adc_o   <= 1'b0;
      drive_o <= 1'b0;
    end else begin
      if (mode_zero_i) latch_o <= 1'b0;
      else if (hit_i) begin
        case (mode_i)
          MD_SET:  latch_o <= 1'b1;
          MD_CLR:  latch_o <= 1'b0;
          MD_TOG:  latch_o <= ~latch_o;
          default: latch_o <= latch_o;
        endcase
      end
      if (hit_i && mode_active(mode_i)) flag_o <= 1'b1;
      else if (flag_clr_i)              flag_o <= 1'b0;
      trig_o  <= sev_hit_o;
      adc_o   <= sev_hit_o && adc_en_i;
      drive_o <= oe_i && mode_drives(mode_i);
    end
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i && mode_active(mode_i) |=> flag_o);
  // R7
  adc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    adc_o |-> trig_o && $past(adc_en_i));
  // R12
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_active(mode_i) && !mode_zero_i && !flag_clr_i |=> $stable(flag_o) && $stable(latch_o));
  // R13
  drive_chk: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> $past(oe_i));
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 8,
  localparam int NB = TW / DW,
  localparam int SELW = $clog2(NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            oe_in,
  input  logic            flag_clr,
  input  logic            ovf_clr,
  input  logic            adc_en,
  output logic [TW-1:0]   timer_o,
  output logic            pin_o,
  output logic            pin_drive_o,
  output logic            cmp_flag_o,
  output logic            ovf_flag_o,
  output logic            trig_o,
  output logic            adc_start_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [TW-1:0]     cmp_val;
  logic [MODE_W-1:0] mode;
  logic              cmp_wr, mode_zero, hit, sev_hit;

  cmp_regs #(.TW(TW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_o(cmp_val), .mode_o(mode), .cmp_wr_o(cmp_wr), .mode_zero_o(mode_zero)
  );

  cmp_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_en), .sev_hit_i(sev_hit),
    .cmp_wr_i(cmp_wr), .ovf_clr_i(ovf_clr), .cnt_o(timer_o), .ovf_o(ovf_flag_o)
  );

  cmp_match #(.TW(TW)) u_match (
    .clk(clk), .rst(rst), .tick_i(tick_en), .cnt_i(timer_o), .cmp_i(cmp_val),
    .hit_o(hit)
  );

  cmp_action u_act (
    .clk(clk), .rst(rst), .hit_i(hit), .mode_i(mode), .mode_zero_i(mode_zero),
    .oe_i(oe_in), .flag_clr_i(flag_clr), .adc_en_i(adc_en),
    .sev_hit_o(sev_hit), .latch_o(pin_o), .flag_o(cmp_flag_o), .trig_o(trig_o),
    .adc_o(adc_start_o), .drive_o(pin_drive_o)
  );

  // R11
  zero_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_zero |=> !pin_o);
  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> timer_o == '0 && !cmp_flag_o && !ovf_flag_o && !trig_o);
endmodule

// File: tb/sim_cmp_event_unit.sv
module sim_cmp_event_unit;
  timeunit 1ns; timeprecision 1ps;

  typedef enum int {S_TMR, S_PIN, S_DRV, S_FLG, S_OVF, S_TRG, S_ADC} sig_e;
  typedef struct {
    sig_e        sig;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        oe_in = 1'b0, flag_clr = 1'b0, ovf_clr = 1'b0, adc_en = 1'b0;
  logic [15:0] timer_o;
  logic        pin_o, pin_drive_o, cmp_flag_o, ovf_flag_o, trig_o, adc_start_o;

  item_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_event_unit u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .oe_in(oe_in), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
    .adc_en(adc_en), .timer_o(timer_o), .pin_o(pin_o), .pin_drive_o(pin_drive_o),
    .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o), .trig_o(trig_o),
    .adc_start_o(adc_start_o)
  );

  function automatic logic [15:0] peek(sig_e s);
    case (s)
      S_TMR:   return timer_o;
      S_PIN:   return {15'd0, pin_o};
      S_DRV:   return {15'd0, pin_drive_o};
      S_FLG:   return {15'd0, cmp_flag_o};
      S_OVF:   return {15'd0, ovf_flag_o};
      S_TRG:   return {15'd0, trig_o};
      default: return {15'd0, adc_start_o};
    endcase
  endfunction

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (peek(it.sig) !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %0h expected %0h", it.req, it.sig.name(),
                 peek(it.sig), it.exp);
      end
    end
  end

  task automatic expect_sig(sig_e s, logic [15:0] v, string req);
    item_t it;
    it.sig = s; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    step(n);
    tick_en = 1'b0;
  endtask

  task automatic pulse_flag_clr();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    expect_sig(S_TMR, 16'd0, "R1"); expect_sig(S_PIN, 16'd0, "R1");
    expect_sig(S_FLG, 16'd0, "R1"); expect_sig(S_TRG, 16'd0, "R1");
    expect_sig(S_OVF, 16'd0, "R1"); expect_sig(S_DRV, 16'd0, "R1");

    // R2 counting on enable only
    ticks(5); expect_sig(S_TMR, 16'd5, "R2");
    step(3);  expect_sig(S_TMR, 16'd5, "R2");

    // R4 set mode, R13 drive
    oe_in = 1'b1;
    wr(2'd2, 8'h08); wr(2'd0, 8'd8);
    expect_sig(S_DRV, 16'd1, "R13");
    ticks(3); step(1);
    expect_sig(S_PIN, 16'd1, "R4"); expect_sig(S_FLG, 16'd1, "R3");
    expect_sig(S_TMR, 16'd8, "R3");

    // R5 no repeat while timer sits on the matching value
    pulse_flag_clr();
    wr(2'd2, 8'h02); step(3);
    expect_sig(S_FLG, 16'd0, "R5"); expect_sig(S_PIN, 16'd1, "R5");

    // R4 toggle, then hold for R5
    wr(2'd0, 8'd10); ticks(2); step(1);
    expect_sig(S_PIN, 16'd0, "R4"); expect_sig(S_FLG, 16'd1, "R3");
    step(4); expect_sig(S_PIN, 16'd0, "R5");
    wr(2'd0, 8'd12); ticks(2); step(1);
    expect_sig(S_PIN, 16'd1, "R4");

    // R4 clear mode
    wr(2'd2, 8'h09); wr(2'd0, 8'd14); ticks(2); step(1);
    expect_sig(S_PIN, 16'd0, "R4");

    // R11 zero mode write forces latch low
    wr(2'd2, 8'h08); wr(2'd0, 8'd16); ticks(2); step(1);
    expect_sig(S_PIN, 16'd1, "R4");
    wr(2'd2, 8'h00);
    expect_sig(S_PIN, 16'd0, "R11");
    step(1); expect_sig(S_DRV, 16'd0, "R13");

    // R12 undefined mode does nothing
    pulse_flag_clr();
    wr(2'd2, 8'h05); wr(2'd0, 8'd18); ticks(2); step(1);
    expect_sig(S_FLG, 16'd0, "R12"); expect_sig(S_PIN, 16'd0, "R12");
    expect_sig(S_DRV, 16'd0, "R13");

    // R13 output enable low
    wr(2'd2, 8'h08); oe_in = 1'b0; step(2);
    expect_sig(S_DRV, 16'd0, "R13");
    oe_in = 1'b1; step(2);
    expect_sig(S_DRV, 16'd1, "R13");

    // R6 interrupt only
    wr(2'd2, 8'h0A); wr(2'd0, 8'd20); ticks(2); step(1);
    expect_sig(S_FLG, 16'd1, "R6"); expect_sig(S_PIN, 16'd0, "R6");
    expect_sig(S_DRV, 16'd0, "R6");
    pulse_flag_clr(); expect_sig(S_FLG, 16'd0, "R3");

    // R7 / R8 trigger with converter enabled
    adc_en = 1'b1;
    wr(2'd2, 8'h0B); wr(2'd0, 8'd25); ticks(5); step(1);
    expect_sig(S_TRG, 16'd1, "R7"); expect_sig(S_ADC, 16'd1, "R7");
    expect_sig(S_FLG, 16'd1, "R3"); expect_sig(S_TMR, 16'd25, "R8");
    step(1);
    expect_sig(S_TRG, 16'd0, "R7"); expect_sig(S_ADC, 16'd0, "R7");
    expect_sig(S_TMR, 16'd25, "R8");
    ticks(1);
    expect_sig(S_TMR, 16'd0, "R8"); expect_sig(S_OVF, 16'd0, "R9");

    // R7 converter disabled, R10 cancel by compare write
    adc_en = 1'b0;
    ticks(25); step(1);
    expect_sig(S_TRG, 16'd1, "R7"); expect_sig(S_ADC, 16'd0, "R7");
    wr(2'd0, 8'd40);
    ticks(1); expect_sig(S_TMR, 16'd26, "R10");

    // R8 period with continuous enable
    ticks(15);
    expect_sig(S_TMR, 16'd0, "R8"); expect_sig(S_TRG, 16'd1, "R7");
    ticks(41); expect_sig(S_TMR, 16'd0, "R8");

    // R2 overflow
    wr(2'd2, 8'h00);
    ticks(65535);
    expect_sig(S_TMR, 16'hFFFF, "R2"); expect_sig(S_OVF, 16'd0, "R2");
    ticks(1);
    expect_sig(S_TMR, 16'd0, "R2"); expect_sig(S_OVF, 16'd1, "R2");
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    expect_sig(S_OVF, 16'd0, "R2");

    // R9 trigger restart from all ones leaves overflow clear
    wr(2'd2, 8'h0B); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    ticks(65535); expect_sig(S_TMR, 16'hFFFF, "R9");
    ticks(1);
    expect_sig(S_TMR, 16'd0, "R9"); expect_sig(S_OVF, 16'd0, "R9");

    step(1);
    @(negedge clk); #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule